// File: doc/BRIEF.md
# Memory Scrub Engine with Failed-Component Check

This engine repairs correctable errors in a memory whose words each hold a 32-byte payload and a 4-byte check field. The two fields are read and written together. The engine runs one scrub at a time. A demand scrub arrives with its own address and rank. A patrol scrub comes from an internal address walker that a programmable interval timer paces.

For each scrub the engine works in this order:
1. It reads the word through a valid/ready memory port.
2. It passes the payload and the check field to an external correction unit.
3. It receives the repaired fields, an error weight and the index of the corrected 4-bit symbol.
4. It writes both repaired fields back to the same address when the correction is accepted.

The engine keeps one register per rank that holds the identity of that rank's known-failed component. A multi-symbol correction is trusted only when it lands on that component. Any other multi-symbol correction is treated as uncorrectable and raises a fatal error. Sticky flags record corrected and fatal events together with the rank and address of the most recent event. Software clears the flags with a write-one-to-clear strobe.

Top module: `scrub_engine`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy`, `ce_flag`, `fatal_flag`, `rd_req_valid`, `wr_valid`, `scrub_done` and `scrub_fatal` are 0. All failed-component registers reset to 0.
- R2: An accepted demand scrub (`dmd_valid` and `dmd_ready` at a clock edge) issues one read of the demanded address and rank. It then presents exactly the returned payload and check field on `ecc_pay`/`ecc_chk`, with `ecc_req_valid` high for one cycle.
- R3: A correction result with weight 0 causes no write. The scrub ends with `scrub_done` high for exactly one cycle, and the engine then accepts new work.
- R4: A result with weight 1 writes the corrected payload and corrected check field back to the address and rank that were read. It then sets `ce_flag`, loads `err_rank`/`err_addr` and pulses `scrub_done`.
- R5: A result with weight 2 or more is handled as in R4 when the corrected symbol maps to the failed component recorded for the scrubbed rank.
- R6: A result with weight 2 or more whose symbol does not map to the recorded component pulses `scrub_fatal` for one cycle. It also sets `fatal_flag` with rank and address and performs no write.
- R7: Symbols 0..71 are 4-bit symbols. With `dev_x8`=1 a symbol maps to component `sym/2`. With `dev_x8`=0 it maps to x4 pair `sym mod 36`, so pair p covers symbols p and p+36. Each rank's register is loaded by `cfg_we` with `cfg_rank`/`cfg_comp`.
- R8: Only one scrub is active at a time. `dmd_ready` is low whenever `busy` is high, and a waiting request is not accepted until the engine is idle.
- R9: When a demand request and a pending patrol step are both waiting as the engine goes idle, the demand is served first.
- R10: While `patrol_en` is high the timer expires every `patrol_interval`+1 cycles and marks one patrol step pending. Steps walk addresses 0..`patrol_top` in order and then wrap to 0, and the rank advances by one on each wrap. With `patrol_en` low no patrol read is issued.
- R11: `stat_clr[0]` clears `ce_flag` and `stat_clr[1]` clears `fatal_flag`. A set in the same cycle wins, and otherwise each flag holds.
- R12: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_rank`, `wr_pay` and `wr_chk` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load a failed-component register |
| cfg_rank | input | 2 | Rank whose register is loaded |
| cfg_comp | input | 6 | Encoded failed component (x8 device or x4 pair) |
| dev_x8 | input | 1 | 1: x8 devices, 0: x4 devices |
| patrol_en | input | 1 | Enable patrol timer |
| patrol_interval | input | 16 | Timer period minus one, in cycles |
| patrol_top | input | 8 | Last patrol address before wrap |
| dmd_valid | input | 1 | Demand scrub request |
| dmd_ready | output | 1 | Demand accepted at this edge when valid |
| dmd_addr | input | 8 | Demand address |
| dmd_rank | input | 2 | Demand rank |
| rd_req_valid | output | 1 | Read request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_addr | output | 8 | Read address |
| rd_rank | output | 2 | Read rank |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_pay | input | 256 | Read payload |
| rd_chk | input | 32 | Read check field |
| ecc_req_valid | output | 1 | Word handed to correction unit |
| ecc_pay | output | 256 | Payload to correction unit |
| ecc_chk | output | 32 | Check field to correction unit |
| ecc_rsp_valid | input | 1 | Correction result valid |
| ecc_fix_pay | input | 256 | Corrected payload |
| ecc_fix_chk | input | 32 | Corrected check field |
| ecc_weight | input | 3 | Number of corrected symbols, 0 = clean |
| ecc_sym | input | 7 | Index of the corrected symbol |
| wr_valid | output | 1 | Write-back request |
| wr_ready | input | 1 | Write-back accepted |
| wr_addr | output | 8 | Write address |
| wr_rank | output | 2 | Write rank |
| wr_pay | output | 256 | Payload written |
| wr_chk | output | 32 | Check field written |
| busy | output | 1 | A scrub is in progress |
| scrub_done | output | 1 | One-cycle pulse at the end of a scrub |
| scrub_fatal | output | 1 | One-cycle pulse on an uncorrectable result |
| stat_clr | input | 2 | Write-one-to-clear strobe for the sticky flags |
| ce_flag | output | 1 | Sticky corrected-error flag |
| fatal_flag | output | 1 | Sticky fatal-error flag |
| err_rank | output | 2 | Rank of the latest event |
| err_addr | output | 8 | Address of the latest event |

## Verification
A stale or corrupted job register would surface within two cycles of acceptance, as a read address or rank that differs from the request. It would surface again several cycles later as a write-back to the wrong word. A wrong failed-component entry or a wrong symbol mapping flips the outcome of a multi-symbol result at the evaluation edge: a fatal pulse appears where a write was expected, or the reverse. A drifting patrol walker shows only over a sequence of steps, as an address order or rank advance that departs from the programmed top. The directed runs therefore record every read port transaction and compare the whole order.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    parameter int PAY_BYTES = 32;
    parameter int CHK_BYTES = 4;
    parameter int ADDR_W    = 8;
    parameter int RANK_W    = 2;
    parameter int WGT_W     = 3;

    localparam int PAY_W = PAY_BYTES * 8;
    localparam int CHK_W = CHK_BYTES * 8;
    // 4-bit symbols across payload plus check field
    localparam int NSYM  = (PAY_BYTES + CHK_BYTES) * 2;
    localparam int SYM_W = $clog2(NSYM);
    localparam int NCOMP = NSYM / 2;
    localparam int CID_W = $clog2(NCOMP);
    localparam int NRANK = 1 << RANK_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RDREQ,
        ST_RDWAIT,
        ST_CHECK,
        ST_EVAL,
        ST_WBACK,
        ST_DONE,
        ST_FATAL
    } scrub_state_e;

    typedef enum logic [1:0] {
        VERDICT_CLEAN,
        VERDICT_FIX,
        VERDICT_FATAL
    } verdict_e;

    typedef struct packed {
        logic [RANK_W-1:0] rank;
        logic [ADDR_W-1:0] addr;
    } scrub_job_t;

    // x8: two adjacent symbols per device; x4: a failed pair spans symbol p and p+NCOMP
    function automatic logic [CID_W-1:0] sym_to_comp(input logic [SYM_W-1:0] sym,
                                                     input logic x8);
        if (x8)
            return CID_W'(sym >> 1);
        else if (sym >= SYM_W'(NCOMP))
            return CID_W'(sym - SYM_W'(NCOMP));
        else
            return CID_W'(sym);
    endfunction

endpackage

// File: rtl/scrub_patrol.sv
module scrub_patrol #(
    parameter int ADDR_W = 8,
    parameter int RANK_W = 2,
    parameter int TMR_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [TMR_W-1:0]  interval,
    input  logic [ADDR_W-1:0] top,
    input  logic              take,
    output logic              pending,
    output logic [ADDR_W-1:0] step_addr,
    output logic [RANK_W-1:0] step_rank
);

    logic [TMR_W-1:0]  cnt_q;
    logic              pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic [RANK_W-1:0] rank_q;
    logic              expire;

    assign expire = en && (cnt_q >= interval);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            addr_q <= '0;
            rank_q <= '0;
        end else begin
            if (!en || expire)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;

            if (take)
                pend_q <= 1'b0;
            if (expire)
                pend_q <= 1'b1;
            if (!en)
                pend_q <= 1'b0;

            if (take) begin
                if (addr_q >= top) begin
                    addr_q <= '0;
                    rank_q <= rank_q + 1'b1;
                end else begin
                    addr_q <= addr_q + 1'b1;
                end
            end
        end
    end

    assign pending   = pend_q;
    assign step_addr = addr_q;
    assign step_rank = rank_q;

endmodule

// File: rtl/scrub_failmap.sv
module scrub_failmap
    import scrub_pkg::*;
#(
    parameter int R_W = RANK_W,
    parameter int C_W = CID_W,
    parameter int S_W = SYM_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [R_W-1:0] cfg_rank,
    input  logic [C_W-1:0] cfg_comp,
    input  logic           x8,
    input  logic [R_W-1:0] look_rank,
    input  logic [S_W-1:0] sym,
    output logic           hit
);

    localparam int NR = 1 << R_W;

    logic [C_W-1:0] comp_q [NR];

    for (genvar g = 0; g < NR; g++) begin : g_rank
        always_ff @(posedge clk) begin
            if (rst)
                comp_q[g] <= '0;
            else if (cfg_we && cfg_rank == R_W'(g))
                comp_q[g] <= cfg_comp;
        end
    end

    assign hit = (C_W'(sym_to_comp(SYM_W'(sym), x8)) == comp_q[look_rank]);

endmodule

// File: rtl/scrub_status.sv
module scrub_status #(
    parameter int ADDR_W = 8,
    parameter int RANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_ce,
    input  logic              set_fatal,
    input  logic [RANK_W-1:0] ev_rank,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [1:0]        clr,
    output logic              ce,
    output logic              fatal,
    output logic [RANK_W-1:0] rank,
    output logic [ADDR_W-1:0] addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ce    <= 1'b0;
            fatal <= 1'b0;
            rank  <= '0;
            addr  <= '0;
        end else begin
            if (set_ce)
                ce <= 1'b1;
            else if (clr[0])
                ce <= 1'b0;
            if (set_fatal)
                fatal <= 1'b1;
            else if (clr[1])
                fatal <= 1'b0;
            if (set_ce || set_fatal) begin
                rank <= ev_rank;
                addr <= ev_addr;
            end
        end
    end

endmodule

// File: rtl/scrub_engine.sv
module scrub_engine
    import scrub_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [RANK_W-1:0] cfg_rank,
    input  logic [CID_W-1:0]  cfg_comp,
    input  logic              dev_x8,
    input  logic              patrol_en,
    input  logic [TMR_W-1:0]  patrol_interval,
    input  logic [ADDR_W-1:0] patrol_top,
    input  logic              dmd_valid,
    output logic              dmd_ready,
    input  logic [ADDR_W-1:0] dmd_addr,
    input  logic [RANK_W-1:0] dmd_rank,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [RANK_W-1:0] rd_rank,
    input  logic              rd_rsp_valid,
    input  logic [PAY_W-1:0]  rd_pay,
    input  logic [CHK_W-1:0]  rd_chk,
    output logic              ecc_req_valid,
    output logic [PAY_W-1:0]  ecc_pay,
    output logic [CHK_W-1:0]  ecc_chk,
    input  logic              ecc_rsp_valid,
    input  logic [PAY_W-1:0]  ecc_fix_pay,
    input  logic [CHK_W-1:0]  ecc_fix_chk,
    input  logic [WGT_W-1:0]  ecc_weight,
    input  logic [SYM_W-1:0]  ecc_sym,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [RANK_W-1:0] wr_rank,
    output logic [PAY_W-1:0]  wr_pay,
    output logic [CHK_W-1:0]  wr_chk,
    output logic              busy,
    output logic              scrub_done,
    output logic              scrub_fatal,
    input  logic [1:0]        stat_clr,
    output logic              ce_flag,
    output logic              fatal_flag,
    output logic [RANK_W-1:0] err_rank,
    output logic [ADDR_W-1:0] err_addr
);

    scrub_state_e      state_q, state_d;
    scrub_job_t        job_q, job_d;
    logic [PAY_W-1:0]  pay_q;
    logic [CHK_W-1:0]  chk_q;
    logic              pend, take, comp_hit;
    logic [ADDR_W-1:0] pat_addr;
    logic [RANK_W-1:0] pat_rank;
    verdict_e          verdict;
    logic              eval_now, set_ce, set_fatal;

    scrub_patrol #(
        .ADDR_W (ADDR_W),
        .RANK_W (RANK_W),
        .TMR_W  (TMR_W)
    ) u_patrol (
        .clk       (clk),
        .rst       (rst),
        .en        (patrol_en),
        .interval  (patrol_interval),
        .top       (patrol_top),
        .take      (take),
        .pending   (pend),
        .step_addr (pat_addr),
        .step_rank (pat_rank)
    );

    scrub_failmap #(
        .R_W (RANK_W),
        .C_W (CID_W),
        .S_W (SYM_W)
    ) u_fmap (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_rank  (cfg_rank),
        .cfg_comp  (cfg_comp),
        .x8        (dev_x8),
        .look_rank (job_q.rank),
        .sym       (ecc_sym),
        .hit       (comp_hit)
    );

    // multi-symbol result trusted only on the recorded component
    always_comb begin
        if (ecc_weight == '0)
            verdict = VERDICT_CLEAN;
        else if (ecc_weight == WGT_W'(1) || comp_hit)
            verdict = VERDICT_FIX;
        else
            verdict = VERDICT_FATAL;
    end

    assign eval_now  = (state_q == ST_EVAL) && ecc_rsp_valid;
    assign set_ce    = eval_now && (verdict == VERDICT_FIX);
    assign set_fatal = eval_now && (verdict == VERDICT_FATAL);

    always_comb begin
        state_d = state_q;
        job_d   = job_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (dmd_valid) begin
                    job_d.rank = dmd_rank;
                    job_d.addr = dmd_addr;
                    state_d    = ST_RDREQ;
                end else if (pend) begin
                    job_d.rank = pat_rank;
                    job_d.addr = pat_addr;
                    take       = 1'b1;
                    state_d    = ST_RDREQ;
                end
            end
            ST_RDREQ:  if (rd_req_ready) state_d = ST_RDWAIT;
            ST_RDWAIT: if (rd_rsp_valid) state_d = ST_CHECK;
            ST_CHECK:  state_d = ST_EVAL;
            ST_EVAL: begin
                if (ecc_rsp_valid) begin
                    case (verdict)
                        VERDICT_CLEAN: state_d = ST_DONE;
                        VERDICT_FIX:   state_d = ST_WBACK;
                        default:       state_d = ST_FATAL;
                    endcase
                end
            end
            ST_WBACK:  if (wr_ready) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_FATAL:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            job_q   <= '0;
            pay_q   <= '0;
            chk_q   <= '0;
        end else begin
            state_q <= state_d;
            job_q   <= job_d;
            if (state_q == ST_RDWAIT && rd_rsp_valid) begin
                pay_q <= rd_pay;
                chk_q <= rd_chk;
            end else if (set_ce) begin
                pay_q <= ecc_fix_pay;
                chk_q <= ecc_fix_chk;
            end
        end
    end

    scrub_status #(
        .ADDR_W (ADDR_W),
        .RANK_W (RANK_W)
    ) u_status (
        .clk       (clk),
        .rst       (rst),
        .set_ce    (set_ce),
        .set_fatal (set_fatal),
        .ev_rank   (job_q.rank),
        .ev_addr   (job_q.addr),
        .clr       (stat_clr),
        .ce        (ce_flag),
        .fatal     (fatal_flag),
        .rank      (err_rank),
        .addr      (err_addr)
    );

    assign busy          = (state_q != ST_IDLE);
    assign dmd_ready     = (state_q == ST_IDLE);
    assign rd_req_valid  = (state_q == ST_RDREQ);
    assign rd_addr       = job_q.addr;
    assign rd_rank       = job_q.rank;
    assign ecc_req_valid = (state_q == ST_CHECK);
    assign ecc_pay       = pay_q;
    assign ecc_chk       = chk_q;
    assign wr_valid      = (state_q == ST_WBACK);
    assign wr_addr       = job_q.addr;
    assign wr_rank       = job_q.rank;
    assign wr_pay        = pay_q;
    assign wr_chk        = chk_q;
    assign scrub_done    = (state_q == ST_DONE);
    assign scrub_fatal   = (state_q == ST_FATAL);

endmodule

// File: rtl/scrub_engine_chk.sv
module scrub_engine_chk
    import scrub_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              dmd_valid,
    input logic              dmd_ready,
    input logic [ADDR_W-1:0] dmd_addr,
    input logic [RANK_W-1:0] dmd_rank,
    input logic              rd_req_valid,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [RANK_W-1:0] rd_rank,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [RANK_W-1:0] wr_rank,
    input logic [PAY_W-1:0]  wr_pay,
    input logic [CHK_W-1:0]  wr_chk,
    input logic              busy,
    input logic              scrub_done,
    input logic              scrub_fatal,
    input logic [1:0]        stat_clr,
    input logic              ce_flag,
    input logic              fatal_flag
);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> !busy && !ce_flag && !fatal_flag && !wr_valid && !rd_req_valid);

    p_accept_reads_r2: assert property (@(posedge clk) disable iff (rst)
        dmd_valid && dmd_ready |=> rd_req_valid && rd_addr == $past(dmd_addr)
                                   && rd_rank == $past(dmd_rank));

    p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
        scrub_done |=> !scrub_done);

    p_fatal_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        scrub_fatal |-> !wr_valid && fatal_flag && !scrub_done);

    p_one_scrub_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !dmd_ready);

    p_ce_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        ce_flag && !stat_clr[0] |=> ce_flag);

    p_fatal_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        fatal_flag && !stat_clr[1] |=> fatal_flag);

    p_wr_hold_r12: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_rank)
                                  && $stable(wr_pay) && $stable(wr_chk));

endmodule

bind scrub_engine scrub_engine_chk u_chk (.*);

// File: tb/scrub_engine_test.sv
module scrub_engine_test;
    import scrub_pkg::*;

    localparam int TMR_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              cfg_we = 1'b0;
    logic [RANK_W-1:0] cfg_rank = '0;
    logic [CID_W-1:0]  cfg_comp = '0;
    logic              dev_x8 = 1'b1;
    logic              patrol_en = 1'b0;
    logic [TMR_W-1:0]  patrol_interval = '0;
    logic [ADDR_W-1:0] patrol_top = '0;
    logic              dmd_valid = 1'b0;
    logic              dmd_ready;
    logic [ADDR_W-1:0] dmd_addr = '0;
    logic [RANK_W-1:0] dmd_rank = '0;
    logic              rd_req_valid;
    logic              rd_req_ready = 1'b1;
    logic [ADDR_W-1:0] rd_addr;
    logic [RANK_W-1:0] rd_rank;
    logic              rd_rsp_valid = 1'b0;
    logic [PAY_W-1:0]  rd_pay = '0;
    logic [CHK_W-1:0]  rd_chk = '0;
    logic              ecc_req_valid;
    logic [PAY_W-1:0]  ecc_pay;
    logic [CHK_W-1:0]  ecc_chk;
    logic              ecc_rsp_valid = 1'b0;
    logic [PAY_W-1:0]  ecc_fix_pay = '0;
    logic [CHK_W-1:0]  ecc_fix_chk = '0;
    logic [WGT_W-1:0]  ecc_weight = '0;
    logic [SYM_W-1:0]  ecc_sym = '0;
    logic              wr_valid;
    logic              wr_ready = 1'b1;
    logic [ADDR_W-1:0] wr_addr;
    logic [RANK_W-1:0] wr_rank;
    logic [PAY_W-1:0]  wr_pay;
    logic [CHK_W-1:0]  wr_chk;
    logic              busy, scrub_done, scrub_fatal;
    logic [1:0]        stat_clr = 2'b00;
    logic              ce_flag, fatal_flag;
    logic [RANK_W-1:0] err_rank;
    logic [ADDR_W-1:0] err_addr;

    scrub_engine #(.TMR_W(TMR_W)) uut (.*);

    // bench memory and correction model
    logic [PAY_W-1:0] mem_pay [0:63];
    logic [CHK_W-1:0] mem_chk [0:63];
    logic [PAY_W-1:0] fx_pmask = '0;
    logic [CHK_W-1:0] fx_cmask = '0;
    logic [WGT_W-1:0] fx_wgt = '0;
    logic [SYM_W-1:0] fx_sym = '0;
    logic [PAY_W-1:0] seen_pay = '0, last_wpay = '0;
    logic [CHK_W-1:0] seen_chk = '0, last_wchk = '0;
    logic [ADDR_W-1:0] last_waddr = '0;
    logic [RANK_W-1:0] last_wrank = '0;
    logic [RANK_W+ADDR_W-1:0] rd_log [0:15];
    int rd_n = 0, wr_n = 0;
    int n_tests = 0, n_fail = 0;
    int d_cnt, f_cnt, w0;

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem_pay[i] = {8{32'hA5A50000 | i}};
            mem_chk[i] = 32'h5A000000 | i;
        end
        for (int i = 0; i < 16; i++) rd_log[i] = '0;
    end

    initial forever begin
        @(posedge clk);
        rd_rsp_valid <= rd_req_valid && rd_req_ready;
        if (rd_req_valid && rd_req_ready) begin
            rd_pay <= mem_pay[{rd_rank, rd_addr[3:0]}];
            rd_chk <= mem_chk[{rd_rank, rd_addr[3:0]}];
            rd_log[rd_n % 16] <= {rd_rank, rd_addr};
            rd_n <= rd_n + 1;
        end
        ecc_rsp_valid <= ecc_req_valid;
        if (ecc_req_valid) begin
            ecc_fix_pay <= ecc_pay ^ fx_pmask;
            ecc_fix_chk <= ecc_chk ^ fx_cmask;
            ecc_weight  <= fx_wgt;
            ecc_sym     <= fx_sym;
            seen_pay    <= ecc_pay;
            seen_chk    <= ecc_chk;
        end
        if (wr_valid && wr_ready) begin
            wr_n       <= wr_n + 1;
            last_wpay  <= wr_pay;
            last_wchk  <= wr_chk;
            last_waddr <= wr_addr;
            last_wrank <= wr_rank;
            mem_pay[{wr_rank, wr_addr[3:0]}] <= wr_pay;
            mem_chk[{wr_rank, wr_addr[3:0]}] <= wr_chk;
        end
    end

    task automatic chk(input string req, input logic [PAY_W-1:0] act, input logic [PAY_W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_fail(input logic [RANK_W-1:0] r, input logic [CID_W-1:0] c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_rank = r; cfg_comp = c;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic launch(input logic [ADDR_W-1:0] a, input logic [RANK_W-1:0] r);
        @(negedge clk);
        dmd_addr = a; dmd_rank = r; dmd_valid = 1'b1;
        while (!dmd_ready) @(negedge clk);
        @(negedge clk);
        dmd_valid = 1'b0;
    endtask

    task automatic scrub(input logic [ADDR_W-1:0] a, input logic [RANK_W-1:0] r,
                         input logic [WGT_W-1:0] w, input logic [SYM_W-1:0] s,
                         input logic [PAY_W-1:0] pm, input logic [CHK_W-1:0] cm);
        fx_wgt = w; fx_sym = s; fx_pmask = pm; fx_cmask = cm;
        w0 = wr_n; d_cnt = 0; f_cnt = 0;
        launch(a, r);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (scrub_done) d_cnt++;
            if (scrub_fatal) f_cnt++;
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 busy", busy, 0);
        chk("R1 flags", {ce_flag, fatal_flag}, 0);
        chk("R1 ports", {rd_req_valid, wr_valid, scrub_done, scrub_fatal}, 0);
        chk("R1 ready", dmd_ready, 1);
    endtask

    task automatic t_clean();
        logic [PAY_W-1:0] op = mem_pay[{2'd1, 4'd3}];
        logic [CHK_W-1:0] oc = mem_chk[{2'd1, 4'd3}];
        int r0 = rd_n;
        scrub(8'd3, 2'd1, 3'd0, 7'd0, '1, '1);
        chk("R2 one read", rd_n - r0, 1);
        chk("R2 read addr", rd_log[r0 % 16], {2'd1, 8'd3});
        chk("R2 ecc pay", seen_pay, op);
        chk("R2 ecc chk", seen_chk, oc);
        chk("R3 no write", wr_n - w0, 0);
        chk("R3 done once", d_cnt, 1);
        chk("R3 idle", {busy, dmd_ready, ce_flag}, 3'b010);
    endtask

    task automatic t_single();
        logic [PAY_W-1:0] op = mem_pay[{2'd0, 4'd5}];
        logic [CHK_W-1:0] oc = mem_chk[{2'd0, 4'd5}];
        scrub(8'd5, 2'd0, 3'd1, 7'd40, {8{32'h00010000}}, 32'h00000081);
        chk("R4 one write", wr_n - w0, 1);
        chk("R4 wr pay", last_wpay, op ^ {8{32'h00010000}});
        chk("R4 wr chk", last_wchk, oc ^ 32'h00000081);
        chk("R4 wr loc", {last_wrank, last_waddr}, {2'd0, 8'd5});
        chk("R4 flag", {ce_flag, fatal_flag, d_cnt[0]}, 3'b101);
        chk("R4 err loc", {err_rank, err_addr}, {2'd0, 8'd5});
        @(negedge clk); stat_clr = 2'b01;
        @(negedge clk); stat_clr = 2'b00;
        chk("R11 ce cleared", ce_flag, 0);
    endtask

    task automatic t_x8();
        dev_x8 = 1'b1;
        set_fail(2'd2, 6'd10);
        scrub(8'd1, 2'd2, 3'd3, 7'd21, {PAY_W{1'b0}} | 256'hF0, 32'h0);
        chk("R5 x8 match writes", wr_n - w0, 1);
        chk("R5 x8 no fatal", {f_cnt[0], fatal_flag, d_cnt[0]}, 3'b001);
        scrub(8'd2, 2'd2, 3'd2, 7'd23, '1, '1);
        chk("R6 mismatch no write", wr_n - w0, 0);
        chk("R6 fatal pulse", {f_cnt[1:0], d_cnt[1:0]}, 4'b0100);
        chk("R6 fatal flag", {fatal_flag, err_rank, err_addr}, {1'b1, 2'd2, 8'd2});
        @(negedge clk); stat_clr = 2'b10;
        @(negedge clk); stat_clr = 2'b00;
        chk("R11 fatal cleared", fatal_flag, 0);
    endtask

    task automatic t_x4();
        dev_x8 = 1'b0;
        scrub(8'd4, 2'd2, 3'd2, 7'd46, 256'h3, 32'h0);
        chk("R7 x4 upper symbol of pair", {wr_n - w0 == 1, f_cnt == 0}, 2'b11);
        scrub(8'd4, 2'd2, 3'd2, 7'd21, 256'h3, 32'h0);
        chk("R7 x4 mapping differs from x8", {wr_n - w0 == 0, f_cnt == 1}, 2'b11);
        scrub(8'd4, 2'd1, 3'd2, 7'd10, 256'h3, 32'h0);
        chk("R7 other rank register", {wr_n - w0 == 0, f_cnt == 1}, 2'b11);
        dev_x8 = 1'b1;
    endtask

    task automatic t_patrol();
        int n0;
        do_reset();
        fx_wgt = '0;
        patrol_top = 8'd2; patrol_interval = 16'd3;
        n0 = rd_n;
        @(negedge clk); patrol_en = 1'b1;
        for (int k = 0; k < 300 && rd_n < n0 + 5; k++) @(negedge clk);
        patrol_en = 1'b0;
        for (int k = 0; k < 40 && busy; k++) @(negedge clk);
        chk("R10 step0", rd_log[n0 % 16],       {2'd0, 8'd0});
        chk("R10 step1", rd_log[(n0 + 1) % 16], {2'd0, 8'd1});
        chk("R10 step2", rd_log[(n0 + 2) % 16], {2'd0, 8'd2});
        chk("R10 wrap", rd_log[(n0 + 3) % 16],  {2'd1, 8'd0});
        chk("R10 step4", rd_log[(n0 + 4) % 16], {2'd1, 8'd1});
        n0 = rd_n;
        repeat (30) @(negedge clk);
        chk("R10 disabled", rd_n - n0, 0);
    endtask

    task automatic t_priority();
        int n0;
        do_reset();
        wr_ready = 1'b0;
        fx_wgt = 3'd1; fx_pmask = 256'h55; fx_cmask = '0;
        launch(8'd7, 2'd0);
        for (int k = 0; k < 30 && !wr_valid; k++) @(negedge clk);
        fx_wgt = '0;
        patrol_top = 8'd5; patrol_interval = 16'd2; patrol_en = 1'b1;
        repeat (6) @(negedge clk);
        chk("R12 wr held", {wr_valid, wr_rank, wr_addr}, {1'b1, 2'd0, 8'd7});
        dmd_addr = 8'd9; dmd_rank = 2'd3; dmd_valid = 1'b1;
        n0 = rd_n;
        repeat (2) @(negedge clk);
        chk("R8 waits while busy", {dmd_ready, busy, rd_n == n0}, 3'b011);
        wr_ready = 1'b1;
        while (!dmd_ready) @(negedge clk);
        @(negedge clk);
        dmd_valid = 1'b0;
        for (int k = 0; k < 100 && rd_n < n0 + 2; k++) @(negedge clk);
        patrol_en = 1'b0;
        for (int k = 0; k < 40 && busy; k++) @(negedge clk);
        chk("R9 demand first", rd_log[n0 % 16], {2'd3, 8'd9});
        chk("R9 patrol after", rd_log[(n0 + 1) % 16], {2'd0, 8'd0});
    endtask

    initial begin
        t_reset();
        t_clean();
        t_single();
        t_x8();
        t_x4();
        t_patrol();
        t_priority();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule